// File: doc/BRIEF.md
# Keccak Byte-Stream Padder

This block sits in front of a Keccak permutation engine and turns a sequence of byte strings into a stream of whole 136-byte rate blocks. Each string is padded on its own with the legacy Keccak multi-rate rule: a 1 bit, a run of zeros, then a closing 1 bit. No SHA-3 domain-separation bits are added. Bytes from two strings never share a block.

Strings arrive on a valid/ready byte port. The length of a string is presented with its first beat, and the end marker is presented with its final data byte. The padded stream leaves on a second valid/ready port. Every output byte carries side-band tags. These tags give the string index, a signed count of bytes remaining, the original length, markers for the last byte of the block and of the string, a flag showing that the block continues an earlier block of the same string, and a flag for the zero-filled tail of the padding. While the padding bytes are being produced, the input is stalled. A zero-length string is given as a single header beat that carries no data.

Top module: `kpad_stream`

## Requirements
- R1: Data bytes pass through unchanged. On the first byte of a string the remaining tag equals the string length, and it falls by one with every byte sent. A string's final data byte must carry the end marker.
- R2: The first padding byte is 0x01. The padding bytes after it are 0x00. The byte at block offset 135 that ends the string is 0x80.
- R3: When exactly one byte of room is left in the block (length mod 136 = 135), the padding is the single byte 0x81.
- R4: When the length is a nonzero multiple of 136, a whole extra block of padding (0x01, 134 zeros, 0x80) follows the data.
- R5: A zero-length header beat (length 0, end marker set) is consumed without producing output. It is followed by one padding-only block.
- R6: The spare tag is 0 through the data and through the 0x01 byte. It is 1 from the byte after the remaining count reaches zero up to and including the string's last byte.
- R7: The last-of-block tag is 1 on every 136th byte of a string. The last-of-string tag equals last-of-block AND (spare OR remaining == 0).
- R8: The string index is 0 after reset. It is constant within a string and rises by exactly one for each new string.
- R9: The length tag equals the string's original length on every byte of that string, padding included.
- R10: The continues tag is 0 on every byte of a string's first block and 1 on every byte of its later blocks.
- R11: Input ready is low on every cycle that emits a padding byte. The next string's first beat is taken only after the previous string's last byte has been sent.
- R12: While output valid is high and output ready is low, no byte is consumed and the output byte and its tags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 8 | Input data byte |
| in_len | input | LEN_W | String length, sampled on the first beat of a string |
| in_last | input | 1 | End marker on the final data byte or on a zero-length header |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Padded byte stream |
| out_idx | output | IDX_W | String index |
| out_rem | output | LEN_W+2 | Signed remaining count (goes negative in the padding) |
| out_len | output | LEN_W | Original string length |
| out_last_blk | output | 1 | Last byte of a 136-byte block |
| out_last_str | output | 1 | Last byte of the padded string |
| out_cont | output | 1 | Block continues the same string as the previous block |
| out_spare | output | 1 | Zero-filled padding tail flag |

## Verification
The lengths are chosen so that each one exercises a different padding shape:
- 1, 5 and 134: the ordinary split padding, with 0x01, a run of zeros and 0x80.
- 135: the merged single 0x81 byte.
- 136 and 272: a padding-only block after an exact block multiple.
- 137: a string whose data spills one byte into a second block.
- 0: a header beat alone.

Every byte of every string is compared in full against a model built from the length alone: the byte, the index, the remaining count, the length and all four flags. During padding, a junk beat is held on the input to show that it is refused. Stall cycles on the output show that the byte and its tags hold. A reset in the middle of a string shows that the index and framing start over.

// File: rtl/kpad_pkg.sv
`timescale 1ns/1ps
package kpad_pkg;
  localparam int RATE_BYTES = 136;
  localparam logic [7:0] PAD_HEAD = 8'h01;
  localparam logic [7:0] PAD_TAIL = 8'h80;
endpackage

// File: rtl/kpad_rst_sync.sv
`timescale 1ns/1ps
module kpad_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/kpad_byte_sel.sv
`timescale 1ns/1ps
module kpad_byte_sel
  import kpad_pkg::*;
(
  input  logic [7:0] din,
  input  logic       rem_zero,
  input  logic       spare,
  input  logic       last_str,
  output logic [7:0] dout
);
  logic [7:0] pad_byte;

  always_comb begin
    pad_byte = (rem_zero ? PAD_HEAD : 8'h00) | (last_str ? PAD_TAIL : 8'h00);
    dout     = (rem_zero || spare) ? pad_byte : din;
  end
endmodule

// File: rtl/kpad_tracker.sv
`timescale 1ns/1ps
module kpad_tracker
  import kpad_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int IDX_W = 8,
  parameter int REM_W = LEN_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LEN_W-1:0]        new_len,
  input  logic                    start,
  input  logic                    fire,
  output logic                    active,
  output logic signed [REM_W-1:0] cur_rem,
  output logic [LEN_W-1:0]        cur_len,
  output logic [IDX_W-1:0]        idx,
  output logic                    rem_zero,
  output logic                    spare,
  output logic                    cont,
  output logic                    last_blk,
  output logic                    last_str
);
  localparam int POS_W = $clog2(RATE_BYTES);

  logic                    active_q, active_d;
  logic signed [REM_W-1:0] rem_q, rem_d;
  logic [LEN_W-1:0]        len_q, len_d;
  logic [POS_W-1:0]        blk_q, blk_d;
  logic                    spare_q, spare_d;
  logic                    cont_q, cont_d;
  logic [IDX_W-1:0]        idx_q, idx_d;
  logic                    upd_en;

  // current view: before a string opens, the header beat supplies the length
  always_comb begin
    cur_rem  = active_q ? rem_q : $signed({2'b00, new_len});
    cur_len  = active_q ? len_q : new_len;
    rem_zero = (cur_rem == '0);
    last_blk = (blk_q == POS_W'(RATE_BYTES - 1));
    last_str = last_blk && (spare_q || rem_zero);
  end

  always_comb begin
    upd_en   = start || fire;
    active_d = active_q;
    rem_d    = rem_q;
    len_d    = len_q;
    blk_d    = blk_q;
    spare_d  = spare_q;
    cont_d   = cont_q;
    idx_d    = idx_q;
    if (start) begin
      active_d = 1'b1;
      len_d    = new_len;
      rem_d    = cur_rem;
    end
    if (fire) begin
      rem_d   = cur_rem - REM_W'(1);
      blk_d   = last_blk ? '0 : blk_q + POS_W'(1);
      spare_d = (spare_q || rem_zero) && !last_str;
      cont_d  = last_blk ? !last_str : cont_q;
      if (last_str) begin
        active_d = 1'b0;
        idx_d    = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rem_q    <= '0;
      len_q    <= '0;
      blk_q    <= '0;
      spare_q  <= 1'b0;
      cont_q   <= 1'b0;
      idx_q    <= '0;
    end else if (upd_en) begin
      active_q <= active_d;
      rem_q    <= rem_d;
      len_q    <= len_d;
      blk_q    <= blk_d;
      spare_q  <= spare_d;
      cont_q   <= cont_d;
      idx_q    <= idx_d;
    end
  end

  assign active = active_q;
  assign spare  = spare_q;
  assign cont   = cont_q;
  assign idx    = idx_q;

  // R1: remaining count steps down by one per byte sent
  p_rem_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last_str) |=> (rem_q == $past(cur_rem) - REM_W'(1)));
  // R6: spare tail never overlaps the zero-remaining byte
  p_spare_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    spare_q |-> !rem_zero);
  // R8: index rises by exactly one at a string boundary
  p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last_str) |=> (idx_q == $past(idx_q) + IDX_W'(1)));
  // R9: length held for the whole string
  p_len_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !(fire && last_str)) |=> (len_q == $past(len_q)));
  // R10: a new string starts on a fresh, non-continuing block
  p_cont_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last_str) |=> (!cont_q && blk_q == '0 && !spare_q));
endmodule

// File: rtl/kpad_stream.sv
`timescale 1ns/1ps
module kpad_stream
  import kpad_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int IDX_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [7:0]              in_data,
  input  logic [LEN_W-1:0]        in_len,
  input  logic                    in_last,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [7:0]              out_data,
  output logic [IDX_W-1:0]        out_idx,
  output logic signed [LEN_W+1:0] out_rem,
  output logic [LEN_W-1:0]        out_len,
  output logic                    out_last_blk,
  output logic                    out_last_str,
  output logic                    out_cont,
  output logic                    out_spare
);
  localparam int REM_W = LEN_W + 2;

  logic                    rst_sync_n;
  logic                    active, start, fire, is_data, empty_hdr;
  logic signed [REM_W-1:0] cur_rem;
  logic [LEN_W-1:0]        cur_len;
  logic [IDX_W-1:0]        idx;
  logic                    rem_zero, spare, cont, last_blk, last_str;

  kpad_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  kpad_tracker #(.LEN_W(LEN_W), .IDX_W(IDX_W), .REM_W(REM_W)) u_trk (
    .clk(clk), .rst_n(rst_sync_n), .new_len(in_len), .start(start),
    .fire(fire), .active(active), .cur_rem(cur_rem), .cur_len(cur_len),
    .idx(idx), .rem_zero(rem_zero), .spare(spare), .cont(cont),
    .last_blk(last_blk), .last_str(last_str)
  );

  kpad_byte_sel u_sel (
    .din(in_data), .rem_zero(rem_zero), .spare(spare),
    .last_str(last_str), .dout(out_data)
  );

  always_comb begin
    is_data   = !cur_rem[REM_W-1] && !rem_zero;
    empty_hdr = !active && (in_len == '0);
    if (active) begin
      out_valid = is_data ? in_valid : 1'b1;
      in_ready  = is_data && out_ready;
    end else begin
      out_valid = in_valid && !empty_hdr;
      in_ready  = empty_hdr || out_ready;
    end
    fire  = out_valid && out_ready;
    start = !active && in_valid && in_ready;
  end

  assign out_idx      = idx;
  assign out_rem      = cur_rem;
  assign out_len      = cur_len;
  assign out_last_blk = last_blk;
  assign out_last_str = last_str;
  assign out_cont     = cont;
  assign out_spare    = spare;

  // R1: end marker must accompany the final data byte
  p_end_marker_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fire && is_data && cur_rem == REM_W'(1)) |-> in_last);
  // R5: a zero-length header carries the end marker
  p_empty_hdr_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start && empty_hdr) |-> in_last);
  // R11: after a padding byte starts, the next cycle still refuses input until the string ends
  p_pad_refuse_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fire && !is_data && !last_str) |=> !in_ready);
  // R12: a stalled padding byte holds its value and tags
  p_pad_hold_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_ready && active && !is_data) |=>
      (out_valid && $stable(out_data) && $stable(out_rem)));
endmodule

// File: tb/kpad_stream_test.sv
`timescale 1ns/1ps
module kpad_stream_test;
  localparam int LEN_W = 16;
  localparam int IDX_W = 8;
  localparam int NSTR  = 8;
  // stimulus table: length, expected padded size, output stall enable
  localparam int LENS [NSTR] = '{5, 1, 135, 136, 0, 137, 272, 134};
  localparam int NOUT [NSTR] = '{136, 136, 136, 272, 136, 272, 408, 136};
  localparam bit STALL[NSTR] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_last, out_valid, out_ready;
  logic [7:0] in_data, out_data;
  logic [LEN_W-1:0] in_len, out_len;
  logic [IDX_W-1:0] out_idx;
  logic signed [LEN_W+1:0] out_rem;
  logic out_last_blk, out_last_str, out_cont, out_spare;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  kpad_stream #(.LEN_W(LEN_W), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_len(in_len), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_idx(out_idx), .out_rem(out_rem), .out_len(out_len),
    .out_last_blk(out_last_blk), .out_last_str(out_last_str),
    .out_cont(out_cont), .out_spare(out_spare)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input int s, input int j);
    return 8'((s * 29 + j * 7 + 3) & 255);
  endfunction

  // model of one output beat: {valid, data, idx, last_blk, last_str, cont, spare, rem, len}
  function automatic logic [63:0] model(input int s, input int ln, input int j);
    int n = (ln / 136 + 1) * 136;
    logic [7:0] b;
    if (j < ln)                    b = dbyte(s, j);
    else if (j == ln && j == n-1)  b = 8'h81;
    else if (j == ln)              b = 8'h01;
    else if (j == n-1)             b = 8'h80;
    else                           b = 8'h00;
    return {9'd0, 1'b1, b, 8'(s), (j % 136 == 135), (j == n-1), (j >= 136),
            (j > ln), 18'(ln - j), 16'(ln)};
  endfunction

  function automatic logic [63:0] observed();
    return {9'd0, out_valid, out_data, out_idx, out_last_blk, out_last_str,
            out_cont, out_spare, out_rem, out_len};
  endfunction

  function automatic string tag_of(input int ln, input int j);
    int n = (ln / 136 + 1) * 136;
    if (j < ln)                         return "R1";
    if (ln == 0)                        return "R5";
    if (j == ln && j == n-1)            return "R3";
    if (ln % 136 == 0 && j >= ln)       return "R4";
    return "R2";
  endfunction

  task automatic drive(input int s, input int ln, input int j);
    if (j < ln) begin
      in_valid = 1'b1; in_data = dbyte(s, j); in_len = LEN_W'(ln);
      in_last = (j == ln - 1);
    end else begin
      // junk beat held during padding; must be refused (R11)
      in_valid = 1'b1; in_data = 8'hEE; in_len = LEN_W'(7); in_last = 1'b0;
    end
  endtask

  task automatic run_string(input int s, input int ln, input bit stall);
    int n = (ln / 136 + 1) * 136;
    if (ln == 0) begin
      @(negedge clk);
      in_valid = 1'b1; in_len = '0; in_last = 1'b1; in_data = 8'h5A; out_ready = 1'b1;
      #1;
      chk(!out_valid && in_ready, "R5 header", {62'd0, out_valid, in_ready}, 64'd1);
      @(posedge clk);
    end
    for (int j = 0; j < n; j++) begin
      if (stall && (j % 50 == 7)) begin
        @(negedge clk);
        drive(s, ln, j); out_ready = 1'b0;
        #1;
        chk(observed() == model(s, ln, j) && !in_ready, "R12 stall",
            observed(), model(s, ln, j));
        @(posedge clk);
      end
      @(negedge clk);
      drive(s, ln, j); out_ready = 1'b1;
      #1;
      chk(observed() == model(s, ln, j),
          $sformatf("%s R6 R7 R8 R9 R10 str%0d byte%0d", tag_of(ln, j), s, j),
          observed(), model(s, ln, j));
      if (j >= ln)
        chk(!in_ready, "R11 input refused in padding", {63'd0, in_ready}, 64'd0);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_len = '0; in_last = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(!out_valid && out_idx == '0 && !out_cont && !out_spare, "R8 reset state",
        {54'd0, out_valid, out_idx, out_cont}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int s = 0; s < NSTR; s++) begin
      run_string(s, LENS[s], STALL[s]);
      chk(((LENS[s] / 136 + 1) * 136) == NOUT[s], "R4 table size",
          64'(NOUT[s]), 64'((LENS[s] / 136 + 1) * 136));
    end

    // reset in the middle of a string: framing and index restart (R8)
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      drive(NSTR, 10, j); out_ready = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    #1;
    chk(!out_valid && out_idx == '0, "R8 mid-string reset",
        {55'd0, out_valid, out_idx}, 64'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    run_string(0, 2, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule